// File: doc/BRIEF.md
# High-Speed USB Transmit Serializer

This block sits between a link controller and an analog line driver. The link hands it bytes over a byte-wide handshake: a data byte, a valid strobe, a final-byte flag, and a next-data strobe coming back from the block. The block turns those bytes into a serial high-speed USB bit stream at one bit per clock. The stream is bit-stuffed and NRZI-encoded, and it drives two outputs: an output-enable for the driver and a line level, where 1 means the J state and 0 means the K state.

A transfer opens with a command byte. A nonzero packet identifier in that byte makes the block frame the packet. It sends SYNC, then the identifier byte, then the data bytes, then an unstuffed EOP. A zero identifier sends the following bytes raw, with no framing. The next-data strobe acts as backpressure. It rises only in the clock where the shifter is about to empty and another byte is wanted. It stays low while SYNC, stuff bits and the other bit slots go out. If the link has no byte ready at that point, the packet ends there.

Top module: `usb_hs_tx_ser`

## Requirements
- R1: Out of reset, line_oe is 0, line_j is 1 (J) and tx_nxt is 1.
- R2: While idle, a byte with tx_vld high is a transmit command only when bits [7:6] are 2'b01 and bits [5:4] are 2'b00. Its bits [3:0] are the packet identifier. Any other byte is consumed and dropped, and line_oe stays 0.
- R3: With a nonzero identifier P, the stream starts with SYNC. SYNC is 31 zero bits and then a one bit, which appears on the line as K,J,K,… ending K,K. The identifier byte {~P,P} follows it.
- R4: Every byte is sent least-significant bit first, and bytes go out in the order they are accepted.
- R5: After six consecutive one bits, a zero bit is inserted. The count runs across SYNC, the identifier and byte boundaries. A stuff bit that is due after the final data bit is still sent before EOP.
- R6: The line is NRZI-coded: a zero bit toggles the level and a one bit holds it. The first bit of a packet is coded against J.
- R7: A framed packet ends with an EOP of eight bits that are not stuffed: a zero and then seven ones. On the next clock line_oe falls and line_j returns to 1.
- R8: With identifier 0, only the data bytes are sent, stuffed and NRZI-coded, with no SYNC and no EOP. If the command itself carries tx_last, nothing is sent.
- R9: tx_nxt is high whenever the block is idle, and while it waits for the first byte of an unframed transfer. During a packet, tx_nxt is high only in the clock that emits the last bit of a byte when that byte was not flagged final. It is low during SYNC, stuff slots, EOP and every other bit slot.
- R10: If tx_vld is low while tx_nxt is high inside a packet, the packet ends after the current byte, exactly as if that byte had been flagged final.
- R11: A command with a nonzero identifier and tx_last high sends an identifier-only packet: SYNC, the identifier byte and EOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_byte | input | 8 | Command or data byte from the link |
| tx_vld | input | 1 | tx_byte holds a byte |
| tx_last | input | 1 | The byte on tx_byte is the final one of the packet |
| tx_nxt | output | 1 | The byte on tx_byte is taken at this clock edge |
| line_oe | output | 1 | Driver enable, high while bits are on the line |
| line_j | output | 1 | Line level, 1 = J, 0 = K |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 32-bit SYNC, an 8-bit EOP and a stuff run of six. That size lets every one of the 15 identifiers and every one of the 256 data-byte values go through a full framed packet. Runs of ones then meet the stuff rule at every alignment: inside a byte, across byte boundaries and right before EOP. A reference NRZI and stuffing model in the bench predicts each line level. It also predicts the exact slot in which each byte must be taken, so a next-data strobe during a stuff slot or a SYNC slot shows up as a timing mismatch.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

    localparam logic [1:0] CMD_TX = 2'b01;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SYNC,
        S_FIRST,
        S_DATA,
        S_TAIL
    } tx_state_e;

    typedef enum logic [1:0] {
        SLOT_NONE,
        SLOT_DATA,
        SLOT_STUFF,
        SLOT_RAW
    } slot_e;

endpackage

// File: rtl/usb_tx_stuffer.sv
module usb_tx_stuffer
    import usb_tx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  slot_e kind,
    input  logic  slot_bit,
    output logic  pend
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic [RUN_W-1:0] ones_d, ones_q;

    assign pend = (ones_q == RUN_W'(STUFF_RUN));

    always_comb begin
        ones_d = ones_q;
        if (clr) begin
            ones_d = '0;
        end else begin
            unique case (kind)
                SLOT_DATA:  ones_d = slot_bit ? ones_q + RUN_W'(1) : '0;
                SLOT_STUFF: ones_d = '0;
                SLOT_RAW:   ones_d = '0;
                default:    ones_d = ones_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end

    // R5: the run of ones never exceeds the stuff limit
    a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= RUN_W'(STUFF_RUN));

    // R5: a stuff slot restarts the run
    a_r5_stuff_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SLOT_STUFF) |=> (ones_q == '0));

endmodule

// File: rtl/usb_tx_nrzi.sv
module usb_tx_nrzi
    import usb_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_e kind,
    input  logic  slot_bit,
    output logic  line_oe,
    output logic  line_j
);
    typedef struct packed {
        logic oe;
        logic lvl;
    } nrzi_t;

    nrzi_t n_d, n_q;
    logic  en;
    logic  code_bit;

    assign en       = (kind != SLOT_NONE);
    assign code_bit = (kind == SLOT_STUFF) ? 1'b0 : slot_bit;

    always_comb begin
        n_d = n_q;
        if (en) begin
            n_d.oe  = 1'b1;
            n_d.lvl = code_bit ? n_q.lvl : ~n_q.lvl;
        end else begin
            n_d.oe  = 1'b0;
            n_d.lvl = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '{oe: 1'b0, lvl: 1'b1};
        else        n_q <= n_d;
    end

    assign line_oe = n_q.oe;
    assign line_j  = n_q.lvl;

    // R7: an undriven line rests at J
    a_r7_idle_j: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> line_j);

    // R6: a coded zero changes the level
    a_r6_zero_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !code_bit && line_oe) |=> (line_j != $past(line_j)));

    // R6: a coded one keeps the level
    a_r6_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code_bit && line_oe) |=> (line_j == $past(line_j)));

endmodule

// File: rtl/usb_tx_ctrl.sv
module usb_tx_ctrl
    import usb_tx_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SYNC_LEN = 32,
    parameter int EOP_LEN  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_vld,
    input  logic              tx_last,
    input  logic              pend,
    output logic              tx_nxt,
    output slot_e             kind,
    output logic              slot_bit,
    output logic              clr
);
    localparam int PID_W = BYTE_W / 2;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int SC_MX = (SYNC_LEN > EOP_LEN) ? SYNC_LEN : EOP_LEN;
    localparam int SC_W  = $clog2(SC_MX);

    typedef struct packed {
        tx_state_e         st;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              last;
        logic              pid;
        logic [SC_W-1:0]   sc;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: S_IDLE, sh: '0, cnt: '0,
                                   last: 1'b0, pid: 1'b0, sc: '0};

    ctrl_t r_d, r_q;

    logic [PID_W-1:0] cmd_pid;
    logic             cmd_ok;

    assign cmd_pid = tx_byte[PID_W-1:0];
    assign cmd_ok  = (tx_byte[BYTE_W-1 -: 2] == CMD_TX)
                  && (tx_byte[BYTE_W-3:PID_W] == '0);

    always_comb begin
        r_d      = r_q;
        kind     = SLOT_NONE;
        slot_bit = 1'b0;
        tx_nxt   = 1'b0;
        clr      = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                tx_nxt = 1'b1;
                if (tx_vld && cmd_ok) begin
                    clr = 1'b1;
                    if (cmd_pid != '0) begin
                        r_d.pid  = 1'b1;
                        r_d.sh   = {~cmd_pid, cmd_pid};
                        r_d.cnt  = CNT_W'(BYTE_W);
                        r_d.last = tx_last;
                        r_d.sc   = '0;
                        r_d.st   = S_SYNC;
                    end else begin
                        r_d.pid = 1'b0;
                        if (!tx_last) r_d.st = S_FIRST;
                    end
                end
            end
            S_SYNC: begin
                if (pend) begin
                    kind = SLOT_STUFF;
                end else begin
                    kind     = SLOT_DATA;
                    slot_bit = (r_q.sc == SC_W'(SYNC_LEN - 1));
                    if (slot_bit) r_d.st = S_DATA;
                    else          r_d.sc = r_q.sc + SC_W'(1);
                end
            end
            S_FIRST: begin
                tx_nxt = 1'b1;
                if (tx_vld) begin
                    r_d.sh   = tx_byte;
                    r_d.cnt  = CNT_W'(BYTE_W);
                    r_d.last = tx_last;
                    r_d.st   = S_DATA;
                end
            end
            S_DATA: begin
                if (pend) begin
                    kind = SLOT_STUFF;
                end else begin
                    kind     = SLOT_DATA;
                    slot_bit = r_q.sh[0];
                    r_d.sh   = r_q.sh >> 1;
                    r_d.cnt  = r_q.cnt - CNT_W'(1);
                    if (r_q.cnt == CNT_W'(1)) begin
                        if (r_q.last) begin
                            r_d.sc = '0;
                            r_d.st = S_TAIL;
                        end else begin
                            tx_nxt = 1'b1;
                            if (tx_vld) begin
                                r_d.sh   = tx_byte;
                                r_d.cnt  = CNT_W'(BYTE_W);
                                r_d.last = tx_last;
                            end else begin
                                r_d.sc = '0;
                                r_d.st = S_TAIL;
                            end
                        end
                    end
                end
            end
            S_TAIL: begin
                if (pend) begin
                    kind = SLOT_STUFF;
                end else if (r_q.pid) begin
                    kind     = SLOT_RAW;
                    slot_bit = (r_q.sc != '0);
                    if (r_q.sc == SC_W'(EOP_LEN - 1)) r_d.st = S_IDLE;
                    else                              r_d.sc = r_q.sc + SC_W'(1);
                end else begin
                    r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTRL_RST;
        else        r_q <= r_d;
    end

    // R9: no byte is requested while SYNC goes out
    a_r9_sync_no_nxt: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_SYNC) |-> !tx_nxt);

    // R9: a byte taken mid-packet refills the whole shifter
    a_r9_take_refills: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && tx_nxt && r_q.st == S_DATA) |=> (r_q.cnt == CNT_W'(BYTE_W)));

    // R7: the EOP counter stays within its length
    a_r7_eop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_TAIL && r_q.pid) |-> (r_q.sc < SC_W'(EOP_LEN)));

    // R5: a pending stuff bit is never replaced by a data bit
    a_r5_stuff_first: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && r_q.st != S_IDLE && r_q.st != S_FIRST) |-> (kind == SLOT_STUFF));

endmodule

// File: rtl/usb_hs_tx_ser.sv
module usb_hs_tx_ser
    import usb_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int SYNC_LEN  = 32,
    parameter int EOP_LEN   = 8,
    parameter int STUFF_RUN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_vld,
    input  logic              tx_last,
    output logic              tx_nxt,
    output logic              line_oe,
    output logic              line_j
);
    slot_e kind;
    logic  slot_bit;
    logic  pend;
    logic  clr;

    usb_tx_ctrl #(
        .BYTE_W  (BYTE_W),
        .SYNC_LEN(SYNC_LEN),
        .EOP_LEN (EOP_LEN)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_byte (tx_byte),
        .tx_vld  (tx_vld),
        .tx_last (tx_last),
        .pend    (pend),
        .tx_nxt  (tx_nxt),
        .kind    (kind),
        .slot_bit(slot_bit),
        .clr     (clr)
    );

    usb_tx_stuffer #(
        .STUFF_RUN(STUFF_RUN)
    ) u_stuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .kind    (kind),
        .slot_bit(slot_bit),
        .pend    (pend)
    );

    usb_tx_nrzi u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .slot_bit(slot_bit),
        .line_oe (line_oe),
        .line_j  (line_j)
    );

endmodule

// File: tb/usb_hs_tx_ser_tb.sv
`timescale 1ns/1ps
module usb_hs_tx_ser_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_vld = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_nxt;
    logic       line_oe;
    logic       line_j;

    always #2 clk = ~clk;

    usb_hs_tx_ser u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_byte(tx_byte),
        .tx_vld (tx_vld),
        .tx_last(tx_last),
        .tx_nxt (tx_nxt),
        .line_oe(line_oe),
        .line_j (line_j)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] pkt_data [0:15];
    logic exp_lvl [0:511];
    logic exp_tk  [0:511];
    logic obs_lvl [0:511];
    logic obs_tk  [0:511];
    int   exp_n, obs_n;
    logic m_lvl;
    int   m_ones;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic b, input logic tk);
        m_lvl = b ? m_lvl : ~m_lvl;
        exp_lvl[exp_n] = m_lvl;
        exp_tk[exp_n]  = tk;
        exp_n++;
    endtask

    task automatic push_data(input logic b, input logic tk);
        if (m_ones == 6) begin
            push(1'b0, 1'b0);
            m_ones = 0;
        end
        push(b, tk);
        m_ones = b ? m_ones + 1 : 0;
    endtask

    task automatic build_exp(input logic [3:0] pid, input int n, input bit under);
        logic [7:0] pb;
        exp_n  = 0;
        m_lvl  = 1'b1;
        m_ones = 0;
        if (pid != 4'h0) begin
            for (int i = 0; i < 31; i++) push_data(1'b0, 1'b0);
            push_data(1'b1, 1'b0);
            pb = {~pid, pid};
            for (int k = 0; k < 8; k++) push_data(pb[k], (k == 7) && (n > 0));
        end
        for (int j = 0; j < n; j++)
            for (int k = 0; k < 8; k++)
                push_data(pkt_data[j][k], (k == 7) && (j < n - 1));
        if (m_ones == 6) push(1'b0, 1'b0);
        if (pid != 4'h0) begin
            push(1'b0, 1'b0);
            for (int k = 0; k < 7; k++) push(1'b1, 1'b0);
        end
        if (under) exp_n = exp_n;
    endtask

    task automatic run_pkt(input logic [3:0] pid, input int n, input bit under,
                           input string tag);
        int   idx, ntake, bad_lvl, bad_tk, first_bad;
        bit   seen, done, take_prev, take;
        build_exp(pid, n, under);
        obs_n = 0; idx = -1; ntake = 0; seen = 0; done = 0; take_prev = 0;
        @(posedge clk); #1;
        tx_byte = {2'b01, 2'b00, pid};
        tx_last = (n == 0);
        tx_vld  = 1'b1;
        for (int c = 0; c < 3000 && !done; c++) begin
            @(negedge clk);
            if (line_oe) begin
                seen = 1;
                if (obs_n < 512) begin
                    obs_lvl[obs_n] = line_j;
                    obs_tk[obs_n]  = take_prev;
                end
                obs_n++;
            end else if (seen) begin
                done = 1;
            end
            take = tx_vld && tx_nxt;
            take_prev = take;
            if (take) ntake++;
            if (!done) begin
                @(posedge clk); #1;
                if (take) begin
                    idx++;
                    if (idx >= n) begin
                        tx_vld = 1'b0; tx_last = 1'b0;
                    end else begin
                        tx_byte = pkt_data[idx];
                        tx_last = (idx == n - 1) && !under;
                    end
                end
            end
        end
        check(done, tag, "packet completed", done, 1);
        check(obs_n == exp_n, tag, "slot count", obs_n, exp_n);
        bad_lvl = 0; bad_tk = 0; first_bad = -1;
        for (int s = 0; s < exp_n && s < obs_n && s < 512; s++) begin
            if (obs_lvl[s] !== exp_lvl[s]) begin
                bad_lvl++;
                if (first_bad < 0) first_bad = s;
            end
            if (obs_tk[s] !== exp_tk[s]) bad_tk++;
        end
        check(bad_lvl == 0, tag, "line level mismatches (first slot)", first_bad, -1);
        check(bad_tk == 0, {tag, " R9"}, "byte take slot mismatches", bad_tk, 0);
        check(ntake == n + 1, {tag, " R9"}, "bytes taken", ntake, n + 1);
        tx_vld = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] ign [0:4];
        int nx, oe_seen, ntk;
        ign[0] = 8'h00; ign[1] = 8'h80; ign[2] = 8'hC5; ign[3] = 8'h53; ign[4] = 8'h3F;

        repeat (4) @(negedge clk);
        check(line_oe == 1'b0, "R1", "line_oe in reset", line_oe, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(line_oe == 1'b0, "R1", "line_oe after reset", line_oe, 0);
        check(line_j == 1'b1, "R1", "line_j after reset", line_j, 1);
        check(tx_nxt == 1'b1, "R1", "tx_nxt after reset", tx_nxt, 1);

        // R2: bytes that are not transmit commands
        for (int b = 0; b < 5; b++) begin
            @(posedge clk); #1;
            tx_byte = ign[b]; tx_vld = 1'b1; tx_last = 1'b0;
            nx = 0; oe_seen = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (tx_nxt) nx++;
                if (line_oe) oe_seen++;
            end
            @(posedge clk); #1 tx_vld = 1'b0;
            check(oe_seen == 0, "R2", "line_oe cycles for non-command byte", oe_seen, 0);
            check(nx == 12, "R2", "tx_nxt cycles while idle", nx, 12);
        end

        // R11, R3, R7: identifier-only packets for every identifier
        for (int p = 1; p < 16; p++) run_pkt(4'(p), 0, 1'b0, "R3 R6 R7 R11");

        // R4, R5, R6: every byte value in a framed packet
        for (int v = 0; v < 256; v++) begin
            pkt_data[0] = 8'(v);
            run_pkt(4'h3, 1, 1'b0, "R4 R5 R6");
        end

        // R5: long runs of ones across byte boundaries
        for (int j = 0; j < 5; j++) pkt_data[j] = 8'hFF;
        run_pkt(4'hA, 5, 1'b0, "R5");
        pkt_data[0] = 8'h7F; pkt_data[1] = 8'hFE; pkt_data[2] = 8'hFC;
        run_pkt(4'h1, 3, 1'b0, "R5 R7");

        // R4: a multi-byte packet with mixed data
        for (int j = 0; j < 16; j++) pkt_data[j] = 8'((j * 37 + 11) ^ (j << 4));
        run_pkt(4'hD, 16, 1'b0, "R4 R9");

        // R8: unframed transfers
        pkt_data[0] = 8'h5A; pkt_data[1] = 8'hFF; pkt_data[2] = 8'h3F;
        run_pkt(4'h0, 3, 1'b0, "R8 R5");
        pkt_data[0] = 8'h00;
        run_pkt(4'h0, 1, 1'b0, "R8 R6");

        // R8: unframed command flagged final sends nothing
        @(posedge clk); #1;
        tx_byte = 8'h40; tx_last = 1'b1; tx_vld = 1'b1;
        ntk = 0; oe_seen = 0;
        @(negedge clk);
        if (tx_vld && tx_nxt) ntk++;
        @(posedge clk); #1 tx_vld = 1'b0; tx_last = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (line_oe) oe_seen++;
        end
        check(oe_seen == 0, "R8", "line_oe cycles for empty unframed command", oe_seen, 0);
        check(ntk == 1, "R8", "command taken", ntk, 1);

        // R10: link runs dry before flagging a final byte
        pkt_data[0] = 8'hC3; pkt_data[1] = 8'h81;
        run_pkt(4'h5, 2, 1'b1, "R10");
        pkt_data[0] = 8'hFF;
        run_pkt(4'h0, 1, 1'b1, "R10 R8");

        // R7: line is back at rest after the last packet
        @(negedge clk);
        check(line_oe == 1'b0 && line_j == 1'b1, "R7", "idle level after packets",
              {line_oe, line_j}, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule